// File: doc/BRIEF.md
# Selectable-Code Load-Modulation Encoder

This block turns a serial stream of data bits into the on/off damping control that drives a transponder's load switch. A field-clock-driven timer sets a bit period of 2n+2 field clocks, from a programmable count n. A line coder then shapes each bit into one of eleven waveforms: NRZ, Manchester, two bi-phase variants, four frequency-shift variants and three phase-shift variants. The phase-shift variants use a subcarrier at half the field clock.

A memory sequencer, outside this block, holds `run` high while a read mode is active. It supplies one data bit each time `bit_req` pulses, and it pulses `seq_wrap` when a new block sequence begins. Each time `run` rises, the encoder first sends a single logic 0. When `marker_en` is set, it then sends a two-bit start marker. The same marker is inserted ahead of the first data bit of every later sequence, and its polarity alternates from one marker to the next. Every transmitted bit passes through an XOR with the inverse-data flag and the sensor level before it is encoded.

Top module: `rfid_mod_encoder`

## Requirements
- R1: While `rst_n` is low, `damp` and `bit_req` are 0. In the cycle after any cycle with `run` low, `damp` and `bit_req` are also 0.
- R2: When `run` rises (sampled at a clock edge), a bit period starts at that edge. Each bit lasts exactly 2n+2 clocks, where n is `rate_n`. `bit_req` is high in the last clock of a bit only when the next bit comes from `data_in`, and `data_in` is sampled at that same edge.
- R3: The first bit after each rising edge of `run` is a logic 0, before inversion.
- R4: With `marker_en` set, a two-bit marker follows the leading 0. A marker is also sent before the next data bit after each `seq_wrap` pulse. Markers alternate: the first after reset is 1,0, the next is 0,1, and so on. No `bit_req` is issued for marker bits.
- R5: Each transmitted bit is XORed with `inv_data` and `sensor_inv`. Both are sampled at the edge where the bit is loaded.
- R6: In mode code 0 (NRZ), `damp` equals the encoded bit for the whole bit period.
- R7: In mode code 1 (Manchester), `damp` is the inverse of the bit during clocks 0..n of the period and equals the bit during clocks n+1..2n+1. So a 1 is a rising edge at mid-bit and a 0 is a falling edge.
- R8: In mode codes 2 and 3 (bi-phase), the level inverts at every bit boundary. Code 2 adds a mid-bit inversion (at clock n+1) for a 1, and code 3 adds it for a 0. The first level after the start is 1.
- R9: In mode codes 4 to 7 (FSK), a subcarrier of period d restarts at each bit boundary. It is high for the first floor(d/2) clocks of each period. For bit 0 / bit 1, d is 5/8 in code 4, 8/5 in code 5, 10/8 in code 6 and 8/10 in code 7.
- R10: In mode codes 8 to 10 (PSK), `damp` is (clock index within the bit, modulo 2) XOR a phase bit. The phase bit is cleared at start. At each bit load it toggles: in code 8 when the new bit differs from the old one, in code 9 when the new bit is 1, and in code 10 when the new bit is 1 and the old one was 0.
- R11: Mode codes 11 to 15 hold `damp` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Field clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | High while a read mode is active; a rise starts transmission |
| rate_n | input | RATE_W | Bit period is 2*rate_n+2 clocks; held stable while running |
| mode | input | 4 | Encoding select, codes as in R6 to R11 |
| inv_data | input | 1 | Inverse-data configuration flag |
| sensor_inv | input | 1 | Sensor inversion level |
| marker_en | input | 1 | Enables the alternating two-bit start marker |
| seq_wrap | input | 1 | Pulse: a new block sequence begins with the next data bit |
| data_in | input | 1 | Next data bit, sampled when bit_req is high |
| bit_req | output | 1 | Data-bit request, one clock before the bit boundary |
| damp | output | 1 | Load damping enable |

## Verification
The hardest case to reach from the ports is the marker polarity carried across separate read entries and across a `seq_wrap` pulse in the middle of a run. Reaching it needs several consecutive runs with markers on, plus a wrap pulse placed partway through a bit, so that the pending-marker state spans a boundary. The bench also flips `sensor_inv` in the middle of a bit to show that inversion takes effect only at the next load. A behavioural model, built from integer counters and a data generator, predicts `damp` and `bit_req` on every clock across all mode codes and several rates, including the shortest period of 2 clocks and the longest of 128.

// File: rtl/rme_pkg.sv
// Shared encodings for the load-modulation encoder.
// Assumes mode codes are carried on a 4-bit bus; unlisted codes mean "silent".
package rme_pkg;

    typedef enum logic [3:0] {
        MD_NRZ       = 4'd0,
        MD_MAN       = 4'd1,
        MD_BIPH_ONE  = 4'd2,
        MD_BIPH_ZERO = 4'd3,
        MD_FSK_A     = 4'd4,
        MD_FSK_A_SW  = 4'd5,
        MD_FSK_B     = 4'd6,
        MD_FSK_B_SW  = 4'd7,
        MD_PSK_CHG   = 4'd8,
        MD_PSK_HIGH  = 4'd9,
        MD_PSK_RISE  = 4'd10
    } mode_e;

    // Source of the bit currently being sent.
    typedef enum logic [1:0] {
        SRC_LEAD  = 2'd0,
        SRC_MARK1 = 2'd1,
        SRC_MARK2 = 2'd2,
        SRC_DATA  = 2'd3
    } src_e;

    localparam int FC_W = 4;   // wide enough for the longest FSK period (10)

endpackage

// File: rtl/rme_bit_timer.sv
// Bit-period timer. Counts field clocks inside a bit of 2*rate_n+2 clocks.
// Assumes rate_n is stable while run is high. Produces the start strobe
// (first clock of a run) and the load strobe (last clock of each bit).
module rme_bit_timer #(
    parameter int RATE_W = 6,
    localparam int CYC_W = RATE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate_n,
    output logic              active,
    output logic [CYC_W-1:0]  cyc,
    output logic              start_p,
    output logic              load_p
);

    logic [CYC_W-1:0] last_idx;

    // Last clock index of a bit: 2n+1.
    assign last_idx = {rate_n, 1'b1};
    assign start_p  = run & ~active;
    assign load_p   = active & run & (cyc >= last_idx);

    // Track whether a transmission is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) active <= 1'b0;
        else        active <= run;
    end

    // Position within the current bit period.
    always_ff @(posedge clk) begin
        if (!rst_n)                cyc <= '0;
        else if (start_p | load_p) cyc <= '0;
        else if (active)           cyc <= cyc + 1'b1;
    end

endmodule

// File: rtl/rme_bit_source.sv
// Bit source selector. Picks the next transmitted bit: the leading zero at
// start, the alternating two-bit marker, or a data bit requested from the
// sequencer. Applies the inverse-data and sensor XOR at load time.
module rme_bit_source
    import rme_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_p,
    input  logic load_p,
    input  logic marker_en,
    input  logic seq_wrap,
    input  logic data_in,
    input  logic inv_data,
    input  logic sensor_inv,
    output logic bit_req,
    output logic nxt_bit
);

    src_e src_q, src_nxt;
    logic pend_q;      // marker owed before the next data bit
    logic pol_q;       // polarity of the next marker
    logic tail_q;      // second bit of the marker in flight
    logic raw_bit;

    // Decide where the bit after the current one comes from.
    always_comb begin
        if (src_q == SRC_MARK1)        src_nxt = SRC_MARK2;
        else if (pend_q && marker_en)  src_nxt = SRC_MARK1;
        else                           src_nxt = SRC_DATA;
    end

    // Raw value of the next bit before inversion.
    always_comb begin
        if (start_p) begin
            raw_bit = 1'b0;
        end else begin
            case (src_nxt)
                SRC_MARK1: raw_bit = ~pol_q;
                SRC_MARK2: raw_bit = tail_q;
                default:   raw_bit = data_in;
            endcase
        end
    end

    assign nxt_bit = raw_bit ^ inv_data ^ sensor_inv;
    assign bit_req = load_p & (src_nxt == SRC_DATA);

    // Source state, marker bookkeeping and polarity alternation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= SRC_LEAD;
            pend_q <= 1'b0;
            pol_q  <= 1'b0;
            tail_q <= 1'b0;
        end else if (start_p) begin
            src_q  <= SRC_LEAD;
            pend_q <= 1'b1;
        end else if (load_p) begin
            src_q  <= src_nxt;
            pend_q <= ((src_nxt == SRC_MARK2) ? pend_q : 1'b0) | seq_wrap;
            if (src_nxt == SRC_MARK1) begin
                pol_q  <= ~pol_q;
                tail_q <= pol_q;
            end
        end else begin
            pend_q <= pend_q | seq_wrap;
        end
    end

endmodule

// File: rtl/rme_line_coder.sv
// Line coder. Holds the bit in flight and shapes it into the damping
// waveform for the selected mode. Assumes the timer's cyc restarts at 0
// on every start and load, and that mode is changed only while idle.
module rme_line_coder
    import rme_pkg::*;
#(
    parameter int RATE_W = 6,
    localparam int CYC_W = RATE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              start_p,
    input  logic              load_p,
    input  logic              nxt_bit,
    input  logic [3:0]        mode,
    input  logic [RATE_W-1:0] rate_n,
    input  logic [CYC_W-1:0]  cyc,
    output logic              damp
);

    logic            cur_q;     // encoded bit being sent
    logic            ph_q;      // PSK phase
    logic            lvl_q;     // bi-phase first-half level
    logic [FC_W-1:0] fc_q;      // FSK subcarrier position
    logic [FC_W-1:0] fdiv;
    logic            mid_flip;
    logic            ph_tog;
    logic            first_half;

    assign first_half = (cyc <= {1'b0, rate_n});

    // Subcarrier period for the FSK variants, chosen by the bit in flight.
    always_comb begin
        case (mode)
            MD_FSK_A:    fdiv = cur_q ? FC_W'(8)  : FC_W'(5);
            MD_FSK_A_SW: fdiv = cur_q ? FC_W'(5)  : FC_W'(8);
            MD_FSK_B:    fdiv = cur_q ? FC_W'(8)  : FC_W'(10);
            MD_FSK_B_SW: fdiv = cur_q ? FC_W'(10) : FC_W'(8);
            default:     fdiv = FC_W'(8);
        endcase
    end

    // Bi-phase mid-bit inversion: on ones for one variant, zeros for the other.
    assign mid_flip = (mode == MD_BIPH_ZERO) ? ~cur_q : cur_q;

    // PSK phase-toggle rule applied at each bit load.
    always_comb begin
        case (mode)
            MD_PSK_CHG:  ph_tog = nxt_bit ^ cur_q;
            MD_PSK_HIGH: ph_tog = nxt_bit;
            MD_PSK_RISE: ph_tog = nxt_bit & ~cur_q;
            default:     ph_tog = 1'b0;
        endcase
    end

    // Per-bit coder state: bit, phase, bi-phase level, subcarrier count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= 1'b0;
            ph_q  <= 1'b0;
            lvl_q <= 1'b0;
            fc_q  <= '0;
        end else if (start_p) begin
            cur_q <= nxt_bit;
            ph_q  <= 1'b0;
            lvl_q <= 1'b1;
            fc_q  <= '0;
        end else if (load_p) begin
            cur_q <= nxt_bit;
            ph_q  <= ph_q ^ ph_tog;
            lvl_q <= ~(lvl_q ^ mid_flip);
            fc_q  <= '0;
        end else begin
            fc_q  <= (fc_q >= fdiv - 1'b1) ? '0 : fc_q + 1'b1;
        end
    end

    // Damping output for the selected encoding.
    always_comb begin
        if (!active) begin
            damp = 1'b0;
        end else begin
            case (mode)
                MD_NRZ:       damp = cur_q;
                MD_MAN:       damp = first_half ? ~cur_q : cur_q;
                MD_BIPH_ONE,
                MD_BIPH_ZERO: damp = first_half ? lvl_q : (lvl_q ^ mid_flip);
                MD_FSK_A,
                MD_FSK_A_SW,
                MD_FSK_B,
                MD_FSK_B_SW:  damp = (fc_q < (fdiv >> 1));
                MD_PSK_CHG,
                MD_PSK_HIGH,
                MD_PSK_RISE:  damp = cyc[0] ^ ph_q;
                default:      damp = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/rfid_mod_encoder.sv
// Top level of the load-modulation encoder. Wires the bit timer, the bit
// source and the line coder. Assumes rate_n and mode are changed only while
// run is low; the sequencer answers bit_req with data_in at the same edge.
module rfid_mod_encoder #(
    parameter int RATE_W = 6,
    localparam int CYC_W = RATE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate_n,
    input  logic [3:0]        mode,
    input  logic              inv_data,
    input  logic              sensor_inv,
    input  logic              marker_en,
    input  logic              seq_wrap,
    input  logic              data_in,
    output logic              bit_req,
    output logic              damp
);

    logic             active_w;
    logic [CYC_W-1:0] cyc_w;
    logic             start_w;
    logic             load_w;
    logic             nxt_bit_w;

    rme_bit_timer #(.RATE_W(RATE_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .rate_n  (rate_n),
        .active  (active_w),
        .cyc     (cyc_w),
        .start_p (start_w),
        .load_p  (load_w)
    );

    rme_bit_source u_source (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_p    (start_w),
        .load_p     (load_w),
        .marker_en  (marker_en),
        .seq_wrap   (seq_wrap),
        .data_in    (data_in),
        .inv_data   (inv_data),
        .sensor_inv (sensor_inv),
        .bit_req    (bit_req),
        .nxt_bit    (nxt_bit_w)
    );

    rme_line_coder #(.RATE_W(RATE_W)) u_coder (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active_w),
        .start_p (start_w),
        .load_p  (load_w),
        .nxt_bit (nxt_bit_w),
        .mode    (mode),
        .rate_n  (rate_n),
        .cyc     (cyc_w),
        .damp    (damp)
    );

endmodule

// File: rtl/rme_checker.sv
// Property checker for the load-modulation encoder, bound into the top.
// Relates the timer's bit position to the coder's output over time.
module rme_checker #(
    parameter int RATE_W = 6,
    localparam int CYC_W = RATE_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic [3:0]        mode,
    input logic [RATE_W-1:0] rate_n,
    input logic              active,
    input logic [CYC_W-1:0]  cyc,
    input logic              bit_req,
    input logic              damp
);

    localparam logic [CYC_W-1:0] ONE = CYC_W'(1);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!damp && !bit_req));

    // R2
    req_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_req |=> !bit_req);

    // R6
    nrz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && mode == 4'd0 && $stable(mode) && cyc != '0)
        |-> $stable(damp));

    // R7
    man_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && mode == 4'd1 && $stable(mode) &&
         $stable(rate_n) && cyc == ({1'b0, rate_n} + ONE))
        |-> (damp != $past(damp)));

    // R8
    biph_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && (mode == 4'd2 || mode == 4'd3) &&
         $stable(mode) && cyc == '0)
        |-> (damp != $past(damp)));

    // R10
    psk_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && mode >= 4'd8 && mode <= 4'd10 &&
         $stable(mode) && cyc != '0)
        |-> (damp != $past(damp)));

endmodule

bind rfid_mod_encoder rme_checker #(.RATE_W(RATE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .mode    (mode),
    .rate_n  (rate_n),
    .active  (active_w),
    .cyc     (cyc_w),
    .bit_req (bit_req),
    .damp    (damp)
);

// File: tb/rfid_mod_encoder_tb.sv
module rfid_mod_encoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [5:0] rate = 6'd0;
    logic [3:0] mode = 4'd0;
    logic       inv = 1'b0;
    logic       sens = 1'b0;
    logic       mk = 1'b0;
    logic       wrap = 1'b0;
    logic       data_in = 1'b0;
    logic       bit_req;
    logic       damp;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rfid_mod_encoder u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .rate_n(rate), .mode(mode),
        .inv_data(inv), .sensor_inv(sens), .marker_en(mk), .seq_wrap(wrap),
        .data_in(data_in), .bit_req(bit_req), .damp(damp)
    );

    // ---------------- behavioural reference model ----------------
    int m_act, m_pos, m_cur, m_ph, m_lvl, m_fc, m_kind, m_pend, m_pol, m_tail;
    logic [15:0] lfsr = 16'hACE1;

    function automatic int fsk_period(int md, int b);
        case (md)
            4: return b ? 8 : 5;
            5: return b ? 5 : 8;
            6: return b ? 8 : 10;
            7: return b ? 10 : 8;
            default: return 8;
        endcase
    endfunction

    function automatic int next_kind();
        if (m_kind == 1) return 2;
        if (m_pend != 0 && mk) return 1;
        return 3;
    endfunction

    function automatic int exp_damp();
        int md, n, mid;
        md = int'(mode); n = int'(rate);
        if (m_act == 0) return 0;
        mid = (md == 3) ? 1 - m_cur : m_cur;
        case (md)
            0: return m_cur;
            1: return (m_pos <= n) ? 1 - m_cur : m_cur;
            2, 3: return (m_pos <= n) ? m_lvl : (m_lvl ^ mid);
            4, 5, 6, 7: return (m_fc < fsk_period(md, m_cur) / 2) ? 1 : 0;
            8, 9, 10: return (m_pos % 2) ^ m_ph;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_now();
        if (m_act == 0) return "R1";
        if (m_kind == 0) return "R3";
        if (m_kind == 1 || m_kind == 2) return "R4";
        if (inv ^ sens) return "R5";
        case (int'(mode))
            0: return "R6";
            1: return "R7";
            2, 3: return "R8";
            4, 5, 6, 7: return "R9";
            8, 9, 10: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Advance the model at each rising edge using the values held before it.
    always @(posedge clk) begin
        int n, st, lo, nk, raw, nb, tog, md, mid;
        n = int'(rate); md = int'(mode);
        if (!rst_n) begin
            m_act = 0; m_pos = 0; m_cur = 0; m_ph = 0; m_lvl = 0; m_fc = 0;
            m_kind = 0; m_pend = 0; m_pol = 0; m_tail = 0;
        end else begin
            st = (run && m_act == 0);
            lo = (run && m_act != 0 && m_pos >= 2 * n + 1);
            if (st) begin
                m_kind = 0; m_pend = 1; m_cur = 0 ^ inv ^ sens;
                m_ph = 0; m_lvl = 1; m_fc = 0; m_pos = 0;
            end else if (lo) begin
                nk = next_kind();
                if (nk == 1) begin
                    raw = 1 - m_pol; m_tail = m_pol; m_pol = 1 - m_pol;
                end else if (nk == 2) begin
                    raw = m_tail;
                end else begin
                    raw = data_in;
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                end
                nb = raw ^ inv ^ sens;
                tog = 0;
                if (md == 8) tog = nb ^ m_cur;
                if (md == 9) tog = nb;
                if (md == 10) tog = nb & (1 - m_cur);
                mid = (md == 3) ? 1 - m_cur : m_cur;
                m_ph = m_ph ^ tog;
                m_lvl = 1 - (m_lvl ^ mid);
                m_cur = nb;
                m_pend = ((nk == 2) ? m_pend : 0) | wrap;
                m_kind = nk;
                m_pos = 0; m_fc = 0;
            end else begin
                m_pend = m_pend | wrap;
                m_fc = (m_fc >= fsk_period(md, m_cur) - 1) ? 0 : m_fc + 1;
                if (m_act != 0) m_pos = m_pos + 1;
            end
            m_act = run;
        end
    end

    // Present the next generated data bit away from the rising edge.
    always @(negedge clk) data_in <= lfsr[0];

    // Compare outputs against the model on every clock.
    always @(negedge clk) begin
        int ed, er;
        if (!done) begin
            ed = exp_damp();
            er = (m_act != 0 && run && m_pos >= 2 * int'(rate) + 1 &&
                  next_kind() == 3) ? 1 : 0;
            tests++;
            if (int'(damp) != ed) begin
                fails++;
                $display("FAIL %s damp mode=%0d pos=%0d: got %0d expected %0d",
                         tag_now(), mode, m_pos, damp, ed);
            end
            tests++;
            if (int'(bit_req) != er) begin
                fails++;
                $display("FAIL R2 bit_req pos=%0d: got %0d expected %0d",
                         m_pos, bit_req, er);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL R2 watchdog: cycles=%0d expected below 150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic check_val(input string tag, input string what,
                             input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic run_case(input int md, input int nn, input int iv, input int sv,
                            input int me, input int bits, input int wrap_at,
                            input int flip_at);
        @(negedge clk); #1;
        run = 1'b0; mode = 4'(md); rate = 6'(nn);
        inv = iv[0]; sens = sv[0]; mk = me[0]; wrap = 1'b0;
        repeat (2) @(negedge clk);
        #1 run = 1'b1;
        for (int c = 0; c < bits * (2 * nn + 2); c++) begin
            @(negedge clk); #1;
            wrap = (c == wrap_at);
            if (c == flip_at) sens = ~sens;
        end
        @(negedge clk); #1;
        wrap = 1'b0; run = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // NRZ, period 8: read the first three bits at their centres (R3, R4).
    task automatic lead_and_marker(input int e1, input int e2);
        @(negedge clk); #1;
        run = 1'b0; mode = 4'd0; rate = 6'd3; inv = 1'b0; sens = 1'b0;
        mk = 1'b1; wrap = 1'b0;
        repeat (2) @(negedge clk);
        #1 run = 1'b1;
        @(posedge clk);
        repeat (3) @(negedge clk);
        check_val("R3", "leading bit", int'(damp), 0);
        repeat (8) @(negedge clk);
        check_val("R4", "marker bit one", int'(damp), e1);
        repeat (8) @(negedge clk);
        check_val("R4", "marker bit two", int'(damp), e2);
        #1 run = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Measure the distance between consecutive data requests (R2).
    task automatic req_gap(input int nn);
        int gap;
        @(negedge clk); #1;
        run = 1'b0; mode = 4'd0; rate = 6'(nn); mk = 1'b0; inv = 1'b0; sens = 1'b0;
        repeat (2) @(negedge clk);
        #1 run = 1'b1;
        for (int k = 0; k < 300 && !bit_req; k++) @(negedge clk);
        check_val("R2", "first request seen", int'(bit_req), 1);
        for (int r = 0; r < 2; r++) begin
            gap = 0;
            for (int k = 0; k < 300; k++) begin
                @(negedge clk);
                gap++;
                if (bit_req) break;
            end
            check_val("R2", "request spacing", gap, 2 * nn + 2);
        end
        #1 run = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check_val("R1", "damp in reset", int'(damp), 0);
        check_val("R1", "bit_req in reset", int'(bit_req), 0);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_val("R1", "damp idle", int'(damp), 0);

        // Marker alternation across entries: 1,0 then 0,1 then 1,0.
        lead_and_marker(1, 0);
        lead_and_marker(0, 1);
        lead_and_marker(1, 0);

        req_gap(5);
        req_gap(0);

        // Every mode code, assorted rates, inversion and markers.
        for (int md = 0; md < 16; md++) begin
            run_case(md, (md * 3) % 8 + 1, md % 2, (md / 2) % 2, md % 3 == 0 ? 1 : 0,
                     16, 40, -1);
        end
        // Boundary rates: shortest and longest bit period.
        run_case(8, 0, 0, 0, 1, 24, 7, -1);
        run_case(1, 0, 1, 0, 0, 24, -1, -1);
        run_case(2, 63, 0, 1, 1, 12, 300, -1);
        // Sensor flip in the middle of a bit, wrap pulses in several modes (R5, R4).
        run_case(0, 4, 0, 0, 1, 30, 55, 23);
        run_case(9, 3, 1, 1, 1, 30, 100, 61);
        run_case(10, 2, 0, 0, 1, 30, 13, 40);
        run_case(7, 9, 0, 0, 1, 20, 150, 77);
        run_case(3, 1, 1, 0, 1, 30, 9, 30);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule